// File: doc/BRIEF.md
# Buffered Pulse Train Generator

This block drives a single counter output pin from a list of pulse descriptions held in an on-chip entry store. Each description carries two 32-bit counts: how many timebase ticks the pin stays high, and how many ticks it then stays low. Together the two counts set the width, period, frequency and duty cycle of that pulse. The host appends descriptions through a write port. A single counter then plays the whole list, so a finite pulse train needs no second counter to gate it.

Playback runs in one of two modes, chosen when the enable input rises. In self-timed mode the descriptions play back to back in write order. In clock-stepped mode each rising edge of an external sample clock moves to the next description, and that pulse repeats until the next edge arrives. Either mode can stop after one pass, which raises a completion flag, or wrap back to the first description and continue. Dropping the enable input stops playback and empties the store.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset `pulse_out`, `done`, `underflow_err` and `overflow_err` are 0 and `buf_level` is 0.
- R2: Each cycle with `wr_valid` high appends one entry and raises `buf_level` by one, up to DEPTH (127). A write while the store holds DEPTH entries is dropped and leaves `buf_level` unchanged. It also sets `overflow_err`, which stays set until the enable input falls.
- R3: In self-timed mode (`cfg_sampled`=0), a rising `cfg_enable` with a non-empty store drives `pulse_out` high in the next cycle. Entry k holds the pin high for its high count of `tick` cycles and then low for its low count of `tick` cycles, and entry k+1 follows at once.
- R4: A high or low count of zero lasts exactly one tick.
- R5: In a single pass (`cfg_regen`=0), the end of the last entry's low phase leaves `pulse_out` at 0 and sets `done`. `done` stays set until the enable input rises again or falls.
- R6: In self-timed mode with `cfg_regen`=1, the last entry's low phase is followed at once by entry 0's high phase, and playback goes on without end.
- R7: In clock-stepped mode (`cfg_sampled`=1), `pulse_out` stays 0 after enable until the first rising edge of `sclk_in`. Each rising edge starts the next entry's high phase, with `pulse_out` at 1 in the next cycle, even if it cuts short a pulse in progress. That entry's high/low pair then repeats until the next edge.
- R8: In clock-stepped mode, an edge that finds no further entry sets `done` and returns `pulse_out` to 0 when `cfg_regen`=0. When `cfg_regen`=1 the same edge restarts at entry 0.
- R9: A rising enable in self-timed single-pass mode with an empty store sets `underflow_err` and keeps `pulse_out` at 0.
- R10: In the cycle after `cfg_enable` falls, `pulse_out`, `done`, `underflow_err` and `overflow_err` are 0 and `buf_level` is 0.
- R11: Mode and regenerate settings are captured when the enable input rises; later changes to them, and `sclk_in` edges in self-timed mode, have no effect on the output.
- R12: A cycle with `tick` low, no sample edge and no change of enable leaves `pulse_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Append one entry this cycle |
| wr_high | input | 32 | High count of the entry being written |
| wr_low | input | 32 | Low count of the entry being written |
| cfg_enable | input | 1 | Rising edge starts playback, falling edge stops and flushes |
| cfg_sampled | input | 1 | 1 = clock-stepped mode, 0 = self-timed mode |
| cfg_regen | input | 1 | 1 = wrap to entry 0 and continue, 0 = single pass |
| tick | input | 1 | Timebase tick, one cycle per count |
| sclk_in | input | 1 | Sample clock, synchronous to clk |
| pulse_out | output | 1 | Generated pulse train |
| done | output | 1 | Single pass finished |
| underflow_err | output | 1 | Self-timed single pass started with an empty store |
| overflow_err | output | 1 | A write was dropped because the store was full |
| buf_level | output | 7 | Number of entries held |

## Verification
A wrong entry index or phase state shows up on `pulse_out` within one pulse. The sequence of high and low run lengths, counted in ticks, stops matching the order in which the entries were written. A fault in the phase counter stretches or shortens a run, and this is visible at the next tick that should have ended it. A wrong fill count shows immediately on `buf_level`. It also shows later as an early or late `done`, as a missed wrap, or as a pulse played from an entry that was never written.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_HIGH = 2'd2,
    PH_LOW  = 2'd3
  } ptg_phase_e;

  function automatic logic ptg_counting(input ptg_phase_e ph);
    return (ph == PH_HIGH) || (ph == PH_LOW);
  endfunction

endpackage

// File: rtl/ptg_entry_buf.sv
module ptg_entry_buf #(
  parameter int DEPTH = 127,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_valid,
  input  logic [CNT_W-1:0] wr_high,
  input  logic [CNT_W-1:0] wr_low,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_high,
  output logic [CNT_W-1:0] rd_low,
  output logic [IDX_W-1:0] fill,
  output logic             overflow
);

  localparam logic [IDX_W-1:0] FULL_LVL = IDX_W'(DEPTH);

  logic [CNT_W-1:0] hi_mem [DEPTH];
  logic [CNT_W-1:0] lo_mem [DEPTH];
  logic             is_full;
  logic             accept;

  assign is_full = (fill == FULL_LVL);
  assign accept  = wr_valid && !flush && !is_full;

  always_ff @(posedge clk) begin
    if (accept) begin
      hi_mem[fill] <= wr_high;
      lo_mem[fill] <= wr_low;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill     <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      fill     <= '0;
      overflow <= 1'b0;
    end else if (wr_valid) begin
      if (is_full) overflow <= 1'b1;
      else         fill     <= fill + 1'b1;
    end
  end

  always_comb begin
    if (rd_addr < FULL_LVL) begin
      rd_high = hi_mem[rd_addr];
      rd_low  = lo_mem[rd_addr];
    end else begin
      rd_high = '0;
      rd_low  = '0;
    end
  end

endmodule

// File: rtl/ptg_phase_timer.sv
module ptg_phase_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] eff_ticks(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [CNT_W-1:0] remain;

  assign expire = tick && (remain == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    remain <= ONE;
    else if (load)                 remain <= eff_ticks(load_val);
    else if (tick && remain > ONE) remain <= remain - ONE;
  end

endmodule

// File: rtl/ptg_sequencer.sv
module ptg_sequencer
  import ptg_pkg::*;
#(
  parameter int DEPTH = 127,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_sampled,
  input  logic             cfg_regen,
  input  logic             sclk_in,
  input  logic [IDX_W-1:0] fill,
  input  logic [CNT_W-1:0] rd_high,
  input  logic [CNT_W-1:0] rd_low,
  input  logic             expire,
  output logic [IDX_W-1:0] rd_addr,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             flush,
  output logic             pulse_out,
  output logic             done,
  output logic             underflow,
  output logic             start_evt,
  output logic             stop_evt,
  output logic             sedge_evt
);

  ptg_phase_e       phase, nx_phase;
  logic [IDX_W-1:0] cur, nx_cur, nxt, nx_nxt;
  logic             samp_q, nx_samp, regen_q, nx_regen;
  logic             nx_out, nx_done, nx_uf;
  logic             en_q, sclk_q;
  logic             sel_hi;
  logic             phase_end;
  logic [IDX_W:0]   cur_inc;

  assign start_evt = cfg_enable && !en_q;
  assign stop_evt  = !cfg_enable && en_q;
  assign flush     = stop_evt;
  assign sedge_evt = sclk_in && !sclk_q && samp_q && cfg_enable && en_q && (phase != PH_IDLE);
  assign phase_end = expire && ptg_counting(phase);
  assign cur_inc   = {1'b0, cur} + 1'b1;
  assign tmr_val   = sel_hi ? rd_high : rd_low;

  always_comb begin
    nx_phase = phase;
    nx_cur   = cur;
    nx_nxt   = nxt;
    nx_out   = pulse_out;
    nx_done  = done;
    nx_uf    = underflow;
    nx_samp  = samp_q;
    nx_regen = regen_q;
    rd_addr  = cur;
    tmr_load = 1'b0;
    sel_hi   = 1'b1;
    if (stop_evt) begin
      nx_phase = PH_IDLE;
      nx_out   = 1'b0;
      nx_done  = 1'b0;
      nx_uf    = 1'b0;
    end else if (start_evt) begin
      nx_samp  = cfg_sampled;
      nx_regen = cfg_regen;
      nx_done  = 1'b0;
      nx_uf    = 1'b0;
      nx_cur   = '0;
      nx_nxt   = '0;
      nx_out   = 1'b0;
      if (cfg_sampled) begin
        nx_phase = PH_WAIT;
      end else if (fill == '0) begin
        nx_phase = PH_IDLE;
        nx_uf    = !cfg_regen;
      end else begin
        rd_addr  = '0;
        tmr_load = 1'b1;
        nx_phase = PH_HIGH;
        nx_out   = 1'b1;
      end
    end else if (sedge_evt) begin
      if (nxt < fill) begin
        rd_addr  = nxt;
        tmr_load = 1'b1;
        nx_cur   = nxt;
        nx_nxt   = nxt + 1'b1;
        nx_phase = PH_HIGH;
        nx_out   = 1'b1;
      end else if (regen_q && fill != '0) begin
        rd_addr  = '0;
        tmr_load = 1'b1;
        nx_cur   = '0;
        nx_nxt   = IDX_W'(1);
        nx_phase = PH_HIGH;
        nx_out   = 1'b1;
      end else if (!regen_q) begin
        nx_phase = PH_IDLE;
        nx_out   = 1'b0;
        nx_done  = 1'b1;
      end
    end else if (phase_end) begin
      if (phase == PH_HIGH) begin
        tmr_load = 1'b1;
        sel_hi   = 1'b0;
        nx_phase = PH_LOW;
        nx_out   = 1'b0;
      end else if (samp_q) begin
        tmr_load = 1'b1;
        nx_phase = PH_HIGH;
        nx_out   = 1'b1;
      end else if (cur_inc < {1'b0, fill}) begin
        rd_addr  = cur_inc[IDX_W-1:0];
        tmr_load = 1'b1;
        nx_cur   = cur_inc[IDX_W-1:0];
        nx_phase = PH_HIGH;
        nx_out   = 1'b1;
      end else if (regen_q) begin
        rd_addr  = '0;
        tmr_load = 1'b1;
        nx_cur   = '0;
        nx_phase = PH_HIGH;
        nx_out   = 1'b1;
      end else begin
        nx_phase = PH_IDLE;
        nx_done  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cur       <= '0;
      nxt       <= '0;
      samp_q    <= 1'b0;
      regen_q   <= 1'b0;
      pulse_out <= 1'b0;
      done      <= 1'b0;
      underflow <= 1'b0;
      en_q      <= 1'b0;
      sclk_q    <= 1'b0;
    end else begin
      phase     <= nx_phase;
      cur       <= nx_cur;
      nxt       <= nx_nxt;
      samp_q    <= nx_samp;
      regen_q   <= nx_regen;
      pulse_out <= nx_out;
      done      <= nx_done;
      underflow <= nx_uf;
      en_q      <= cfg_enable;
      sclk_q    <= sclk_in;
    end
  end

endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int DEPTH = 127,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [CNT_W-1:0] wr_high,
  input  logic [CNT_W-1:0] wr_low,
  input  logic             cfg_enable,
  input  logic             cfg_sampled,
  input  logic             cfg_regen,
  input  logic             tick,
  input  logic             sclk_in,
  output logic             pulse_out,
  output logic             done,
  output logic             underflow_err,
  output logic             overflow_err,
  output logic [IDX_W-1:0] buf_level
);

  logic [IDX_W-1:0] rd_addr;
  logic [CNT_W-1:0] rd_high, rd_low, tmr_val;
  logic             tmr_load, expire, flush;
  logic             start_evt, stop_evt, sedge_evt;

  ptg_entry_buf #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .wr_valid (wr_valid),
    .wr_high  (wr_high),
    .wr_low   (wr_low),
    .rd_addr  (rd_addr),
    .rd_high  (rd_high),
    .rd_low   (rd_low),
    .fill     (buf_level),
    .overflow (overflow_err)
  );

  ptg_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (tick),
    .expire   (expire)
  );

  ptg_sequencer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_enable  (cfg_enable),
    .cfg_sampled (cfg_sampled),
    .cfg_regen   (cfg_regen),
    .sclk_in     (sclk_in),
    .fill        (buf_level),
    .rd_high     (rd_high),
    .rd_low      (rd_low),
    .expire      (expire),
    .rd_addr     (rd_addr),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .flush       (flush),
    .pulse_out   (pulse_out),
    .done        (done),
    .underflow   (underflow_err),
    .start_evt   (start_evt),
    .stop_evt    (stop_evt),
    .sedge_evt   (sedge_evt)
  );

endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
  parameter int DEPTH = 127,
  localparam int IDX_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             cfg_sampled,
  input logic             cfg_regen,
  input logic             tick,
  input logic             pulse_out,
  input logic             done,
  input logic             underflow_err,
  input logic             overflow_err,
  input logic [IDX_W-1:0] fill,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             sedge_evt,
  input logic             tmr_load
);

  localparam logic [IDX_W-1:0] FULL_LVL = IDX_W'(DEPTH);

  a_r2_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && fill == FULL_LVL && !stop_evt |=> overflow_err && fill == FULL_LVL);

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FULL_LVL);

  a_r3_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !cfg_sampled && fill != '0 |=> pulse_out);

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !pulse_out);

  a_r7_edge_high: assert property (@(posedge clk) disable iff (!rst_n)
    sedge_evt && tmr_load |=> pulse_out);

  a_r9_underflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && !cfg_sampled && !cfg_regen && fill == '0 |=> underflow_err && !pulse_out);

  a_r9_underflow_idle: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_err |-> !pulse_out && !done);

  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !pulse_out && !done && !underflow_err && !overflow_err && fill == '0);

  a_r12_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !sedge_evt && !start_evt && !stop_evt |=> $stable(pulse_out));

endmodule

bind pulse_train_gen ptg_checker #(.DEPTH(DEPTH)) u_ptg_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_valid      (wr_valid),
  .cfg_sampled   (cfg_sampled),
  .cfg_regen     (cfg_regen),
  .tick          (tick),
  .pulse_out     (pulse_out),
  .done          (done),
  .underflow_err (underflow_err),
  .overflow_err  (overflow_err),
  .fill          (buf_level),
  .start_evt     (start_evt),
  .stop_evt      (stop_evt),
  .sedge_evt     (sedge_evt),
  .tmr_load      (tmr_load)
);

// File: tb/tb_pulse_train_gen.sv
module tb_pulse_train_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 127;
  localparam int W = 32;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [W-1:0] wr_high = '0, wr_low = '0;
  logic cfg_enable = 1'b0, cfg_sampled = 1'b0, cfg_regen = 1'b0;
  logic tick = 1'b0, sclk_in = 1'b0;
  logic pulse_out, done, underflow_err, overflow_err;
  logic [LW-1:0] buf_level;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD / 2) clk = ~clk;

  pulse_train_gen #(.DEPTH(DEPTH), .CNT_W(W)) dut (.*);

  // bench-side model state
  longint b_hi[DEPTH];
  longint b_lo[DEPTH];
  int  b_fill = 0;
  bit  b_ovf = 0;
  bit  m_out = 0, m_done = 0, m_uf = 0, m_samp = 0, m_regen = 0;
  int  m_state = 0;  // 0 stopped, 1 waiting for edge, 2 high run, 3 low run
  int  m_cur = 0, m_nxt = 0;
  longint m_rem = 1;
  bit  en_prev = 0, sclk_prev = 0;

  function automatic longint ticks_of(input longint v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic begin_high(input int idx);
    m_cur = idx; m_state = 2; m_out = 1; m_rem = ticks_of(b_hi[idx]);
  endtask

  task automatic model_step();
    bit st, sp, se;
    int old_fill;
    st = cfg_enable && !en_prev;
    sp = !cfg_enable && en_prev;
    se = sclk_in && !sclk_prev;
    old_fill = b_fill;
    if (sp) begin
      b_fill = 0; b_ovf = 0;
    end else if (wr_valid) begin
      if (old_fill == DEPTH) b_ovf = 1;
      else begin
        b_hi[old_fill] = longint'(wr_high);
        b_lo[old_fill] = longint'(wr_low);
        b_fill = old_fill + 1;
      end
    end
    if (sp) begin
      m_state = 0; m_out = 0; m_done = 0; m_uf = 0;
    end else if (st) begin
      m_samp = cfg_sampled; m_regen = cfg_regen; m_done = 0; m_uf = 0;
      m_cur = 0; m_nxt = 0; m_out = 0;
      if (cfg_sampled) m_state = 1;
      else if (old_fill == 0) begin m_state = 0; m_uf = !cfg_regen; end
      else begin_high(0);
    end else if (m_samp && se && m_state != 0) begin
      if (m_nxt < old_fill) begin begin_high(m_nxt); m_nxt++; end
      else if (m_regen && old_fill != 0) begin begin_high(0); m_nxt = 1; end
      else if (!m_regen) begin m_state = 0; m_out = 0; m_done = 1; end
    end else if ((m_state == 2 || m_state == 3) && tick) begin
      if (m_rem > 1) m_rem--;
      else if (m_state == 2) begin
        m_state = 3; m_out = 0; m_rem = ticks_of(b_lo[m_cur]);
      end else if (m_samp) begin_high(m_cur);
      else if (m_cur + 1 < old_fill) begin_high(m_cur + 1);
      else if (m_regen) begin_high(0);
      else begin m_state = 0; m_done = 1; end
    end
    en_prev = cfg_enable;
    sclk_prev = sclk_in;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(pulse_out == m_out, cur_req, "pulse_out", pulse_out, m_out);
    check(done == m_done, cur_req, "done", done, m_done);
    check(underflow_err == m_uf, cur_req, "underflow_err", underflow_err, m_uf);
    check(overflow_err == b_ovf, cur_req, "overflow_err", overflow_err, b_ovf);
    check(int'(buf_level) == b_fill, cur_req, "buf_level", buf_level, b_fill);
  endtask

  task automatic write_entry(input longint h, input longint l);
    wr_valid = 1; wr_high = W'(h); wr_low = W'(l);
    cycle();
    wr_valid = 0;
  endtask

  task automatic disable_run();
    cur_req = "R10";
    cfg_enable = 0; tick = 0;
    cycle();
    check(!pulse_out && !done && !underflow_err && !overflow_err && buf_level == 0,
          "R10", "flags/level after disable", {pulse_out, done, underflow_err, overflow_err}, 0);
  endtask

  task automatic run_random(input int n, input bit use_sclk, input bit stop_on_done);
    int sc = 3;
    for (int i = 0; i < n; i++) begin
      if (stop_on_done && m_done) break;
      tick = ($urandom_range(0, 3) != 0);
      if (use_sclk) begin
        sc--;
        if (sc <= 0) begin sclk_in = ~sclk_in; sc = $urandom_range(2, 9); end
      end
      cycle();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!pulse_out && !done && !underflow_err && !overflow_err && buf_level == 0,
          "R1", "reset outputs", {pulse_out, done, underflow_err, overflow_err}, 0);
    rst_n = 1;
    cycle();

    // R2 + R4: load entries, one with zero counts
    cur_req = "R2";
    write_entry(0, 0);
    for (int i = 0; i < 5; i++) write_entry($urandom_range(0, 4), $urandom_range(0, 4));
    check(buf_level == 6, "R2", "level after 6 writes", buf_level, 6);

    // R3/R4/R5: self-timed single pass
    cur_req = "R3";
    cfg_sampled = 0; cfg_regen = 0; cfg_enable = 1; tick = 1;
    cycle();
    check(pulse_out == 1, "R3", "high after enable", pulse_out, 1);
    cur_req = "R4";
    cycle();
    check(pulse_out == 0, "R4", "zero high count lasts one tick", pulse_out, 0);
    cur_req = "R5";
    run_random(400, 0, 1);
    check(done == 1 && pulse_out == 0, "R5", "done after single pass", {done, pulse_out}, 2);
    disable_run();

    // R6/R11: self-timed regen, mode flip and sample edges ignored
    cur_req = "R6";
    for (int i = 0; i < 4; i++) write_entry($urandom_range(0, 5), $urandom_range(0, 5));
    cfg_regen = 1; cfg_enable = 1;
    run_random(150, 0, 0);
    cur_req = "R11";
    cfg_sampled = 1; cfg_regen = 0;
    run_random(150, 1, 0);
    check(done == 0, "R11", "no done after late mode change", done, 0);
    disable_run();

    // R7/R8: clock-stepped single pass
    cur_req = "R7";
    for (int i = 0; i < 5; i++) write_entry($urandom_range(0, 3), $urandom_range(0, 3));
    cfg_sampled = 1; cfg_regen = 0; cfg_enable = 1; sclk_in = 0;
    for (int i = 0; i < 4; i++) begin tick = 1; cycle(); end
    check(pulse_out == 0, "R7", "idle before first sample edge", pulse_out, 0);
    sclk_in = 1; tick = 0;
    cycle();
    check(pulse_out == 1, "R7", "high after sample edge", pulse_out, 1);
    cur_req = "R8";
    run_random(600, 1, 1);
    check(done == 1 && pulse_out == 0, "R8", "done after last sample edge", {done, pulse_out}, 2);
    disable_run();

    // R8: clock-stepped regen
    cur_req = "R8";
    for (int i = 0; i < 3; i++) write_entry($urandom_range(1, 6), $urandom_range(0, 6));
    cfg_regen = 1; cfg_enable = 1;
    run_random(300, 1, 0);
    check(done == 0, "R8", "regen never sets done", done, 0);
    disable_run();

    // R9: underflow
    cur_req = "R9";
    cfg_sampled = 0; cfg_regen = 0; cfg_enable = 1;
    cycle();
    check(underflow_err == 1 && pulse_out == 0, "R9", "underflow on empty start",
          {underflow_err, pulse_out}, 2);
    cycle();
    disable_run();

    // R12: no ticks, output holds
    cur_req = "R12";
    write_entry(3, 3);
    cfg_enable = 1; tick = 0;
    for (int i = 0; i < 10; i++) cycle();
    check(pulse_out == 1, "R12", "held high without ticks", pulse_out, 1);
    tick = 1;
    for (int i = 0; i < 8; i++) cycle();
    disable_run();

    // R2: overflow
    cur_req = "R2";
    for (int i = 0; i < DEPTH + 2; i++) write_entry(i, i);
    check(overflow_err == 1 && buf_level == LW'(DEPTH), "R2", "overflow flag and full level",
          buf_level, DEPTH);
    cfg_enable = 1; cycle();
    disable_run();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule